// File: doc/BRIEF.md
# Interrupt Mask and DMA Request Router

This block keeps the thirteen pending-event flags of a memory-card host controller alongside a thirteen-bit mask. It turns them into one level-sensitive interrupt line for the processor and two DMA request levels, one for receive and one for transmit. The transfer logic raises flags through single-cycle event strobes. Clock start/stop commands and accesses to the receive and transmit data ports take flags down.

A DMA-enable level controls where the two FIFO service flags go. When it is off, they reach the processor interrupt like any other source. When it is on, they are hidden from the processor and appear only on the DMA request outputs. A small register port writes and reads the mask and reads the pending vector. All three outputs come from one register, loaded from the next-state values, so a change becomes visible at the clock edge that captures it.

Top module: `irq_route_top`

## Requirements
- R1: While rst_ni is low and after it is released, the pending vector and the mask read as zero and irq_o, dma_rx_req_o and dma_tx_req_o are low.
- R2: A high bit i of evt_set_i sets pending bit i. The layout is: 0 data done, 1 program done, 2 command end, 3 stop command, 4 clock off, 5 receive FIFO service, 6 transmit FIFO service, 7 timeout, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 card acknowledge. The pending vector is read at reg_addr_i = 1, in bits 12:0.
- R3: A write with reg_addr_i = 0 loads the mask from reg_wdata_i[12:0]. The mask reads back at reg_addr_i = 0, and bits 31:13 read as zero. A write with reg_addr_i = 1 changes neither the mask nor the pending vector.
- R4: With DMA mode off, irq_o is high exactly when some pending bit has its mask bit clear.
- R5: With DMA mode on, pending bits 5 and 6 never drive irq_o, whatever the mask holds. The other bits still follow R4.
- R6: With DMA mode on, dma_rx_req_o equals pending bit 5 and dma_tx_req_o equals pending bit 6. With DMA mode off, both are low.
- R7: clk_stop_i sets pending bit 4 and clk_start_i clears it. If both are high in the same cycle, the bit ends up set.
- R8: rx_rd_i clears pending bit 5 and tx_wr_i clears pending bit 6, leaving every other bit alone. An event strobe for the same bit in the same cycle wins over the clear.
- R9: irq_o and the DMA requests reflect a change of the pending vector, the mask or dma_en_i at the very clock edge that captures that change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_set_i | input | 13 | Per-source event strobes from the transfer logic |
| clk_start_i | input | 1 | Card clock start command |
| clk_stop_i | input | 1 | Card clock stop command |
| rx_rd_i | input | 1 | Receive data port read strobe |
| tx_wr_i | input | 1 | Transmit data port write strobe |
| dma_en_i | input | 1 | Route FIFO service flags to DMA |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = mask, 1 = pending vector |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Processor interrupt level |
| dma_rx_req_o | output | 1 | Receive DMA request level |
| dma_tx_req_o | output | 1 | Transmit DMA request level |

## Verification
The assertions assume that rst_ni is low at time zero and that every strobe input is already at a known level at the first clock edge. They also assume that dma_en_i changes only between edges. The bench meets these assumptions by holding reset from the start, driving every input on the falling edge, and resetting before each sweep point, so pending bits that never clear do not carry over from one point to the next.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned NUM_SRC     = 13;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned SRC_CLK_OFF = 4;
  localparam int unsigned SRC_RX_SVC  = 5;
  localparam int unsigned SRC_TX_SVC  = 6;
endpackage

// File: rtl/irq_req_vec.sv
module irq_req_vec #(
  parameter int unsigned NUM_SRC = irq_route_pkg::NUM_SRC,
  parameter int unsigned CLK_BIT = irq_route_pkg::SRC_CLK_OFF,
  parameter int unsigned RX_BIT  = irq_route_pkg::SRC_RX_SVC,
  parameter int unsigned TX_BIT  = irq_route_pkg::SRC_TX_SVC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_set_i,
  input  logic               clk_start_i,
  input  logic               clk_stop_i,
  input  logic               rx_rd_i,
  input  logic               tx_wr_i,
  output logic [NUM_SRC-1:0] req_d_o,
  output logic [NUM_SRC-1:0] req_q_o
);
  logic [NUM_SRC-1:0] set_v, clr_v;

  always_comb begin
    set_v          = evt_set_i;
    set_v[CLK_BIT] = evt_set_i[CLK_BIT] | clk_stop_i;
    clr_v          = '0;
    clr_v[CLK_BIT] = clk_start_i;
    clr_v[RX_BIT]  = rx_rd_i;
    clr_v[TX_BIT]  = tx_wr_i;
  end

  // set wins over clear on the same bit
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign req_d_o[i] = set_v[i] | (req_q_o[i] & ~clr_v[i]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_q_o[i] <= 1'b0;
      else         req_q_o[i] <= req_d_o[i];
    end
  end

  a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_q_o & $past(evt_set_i)) == $past(evt_set_i)));
  a_r7_stop_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clk_stop_i) |-> req_q_o[CLK_BIT]);
  a_r8_rx_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rx_rd_i && !evt_set_i[RX_BIT]) |-> !req_q_o[RX_BIT]);
  a_r8_tx_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tx_wr_i && !evt_set_i[TX_BIT]) |-> !req_q_o[TX_BIT]);
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned NUM_SRC = irq_route_pkg::NUM_SRC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] mask_d_o,
  output logic [NUM_SRC-1:0] mask_q_o
);
  assign mask_d_o = we_i ? wdata_i : mask_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q_o <= '0;
    else         mask_q_o <= mask_d_o;
  end

  a_r3_mask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!we_i) |-> $stable(mask_q_o));
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned NUM_SRC = irq_route_pkg::NUM_SRC,
  parameter int unsigned RX_BIT  = irq_route_pkg::SRC_RX_SVC,
  parameter int unsigned TX_BIT  = irq_route_pkg::SRC_TX_SVC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_d_i,
  input  logic [NUM_SRC-1:0] mask_d_i,
  input  logic               dma_en_i,
  output logic               irq_o,
  output logic               dma_rx_o,
  output logic               dma_tx_o
);
  localparam logic [NUM_SRC-1:0] FIFO_BITS =
    (NUM_SRC'(1) << RX_BIT) | (NUM_SRC'(1) << TX_BIT);

  logic [NUM_SRC-1:0] eff_mask;
  logic               irq_d, rx_d, tx_d;

  always_comb begin
    eff_mask = mask_d_i | (dma_en_i ? FIFO_BITS : '0);
    irq_d    = |(req_d_i & ~eff_mask);
    rx_d     = dma_en_i & req_d_i[RX_BIT];
    tx_d     = dma_en_i & req_d_i[TX_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o    <= 1'b0;
      dma_rx_o <= 1'b0;
      dma_tx_o <= 1'b0;
    end else begin
      irq_o    <= irq_d;
      dma_rx_o <= rx_d;
      dma_tx_o <= tx_d;
    end
  end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top #(
  parameter int unsigned NUM_SRC = irq_route_pkg::NUM_SRC,
  parameter int unsigned REG_W   = irq_route_pkg::REG_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_set_i,
  input  logic               clk_start_i,
  input  logic               clk_stop_i,
  input  logic               rx_rd_i,
  input  logic               tx_wr_i,
  input  logic               dma_en_i,
  input  logic               reg_we_i,
  input  logic               reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               irq_o,
  output logic               dma_rx_req_o,
  output logic               dma_tx_req_o
);
  import irq_route_pkg::*;
  localparam int unsigned PAD_W = REG_W - NUM_SRC;
  localparam logic [NUM_SRC-1:0] FIFO_BITS =
    (NUM_SRC'(1) << SRC_RX_SVC) | (NUM_SRC'(1) << SRC_TX_SVC);

  logic [NUM_SRC-1:0] req_d, req_q, mask_d, mask_q;
  logic               mask_we;
  logic               unused_wdata_hi;

  assign mask_we         = reg_we_i & ~reg_addr_i;
  assign unused_wdata_hi = ^reg_wdata_i[REG_W-1:NUM_SRC];

  irq_req_vec #(.NUM_SRC(NUM_SRC)) u_req (
    .clk_i, .rst_ni, .evt_set_i, .clk_start_i, .clk_stop_i,
    .rx_rd_i, .tx_wr_i, .req_d_o(req_d), .req_q_o(req_q)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i, .rst_ni, .we_i(mask_we), .wdata_i(reg_wdata_i[NUM_SRC-1:0]),
    .mask_d_o(mask_d), .mask_q_o(mask_q)
  );

  irq_out_stage #(.NUM_SRC(NUM_SRC)) u_out (
    .clk_i, .rst_ni, .req_d_i(req_d), .mask_d_i(mask_d), .dma_en_i,
    .irq_o, .dma_rx_o(dma_rx_req_o), .dma_tx_o(dma_tx_req_o)
  );

  assign reg_rdata_o = {{PAD_W{1'b0}}, (reg_addr_i ? req_q : mask_q)};

  a_r4_r5_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(req_q & ~mask_q & ~($past(dma_en_i) ? FIFO_BITS : '0)));
  a_r6_dma_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!dma_en_i) |-> (!dma_rx_req_o && !dma_tx_req_o));
  a_r6_dma_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dma_en_i) |-> (dma_rx_req_o == req_q[SRC_RX_SVC] &&
                         dma_tx_req_o == req_q[SRC_TX_SVC]));
endmodule

// File: tb/sim_irq_route_top.sv
module sim_irq_route_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] evt_set = '0;
  logic        clk_start = 0, clk_stop = 0, rx_rd = 0, tx_wr = 0, dma_en = 0;
  logic        reg_we = 0, reg_addr = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, dma_rx, dma_tx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [12:0] m_req = '0, m_mask = '0;
  logic        m_dma = 0;

  always #5 clk = ~clk;

  irq_route_top u0 (
    .clk_i(clk), .rst_ni, .evt_set_i(evt_set), .clk_start_i(clk_start),
    .clk_stop_i(clk_stop), .rx_rd_i(rx_rd), .tx_wr_i(tx_wr), .dma_en_i(dma_en),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq), .dma_rx_req_o(dma_rx),
    .dma_tx_req_o(dma_tx)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return |(m_req & ~m_mask & ~(m_dma ? 13'h060 : 13'h000));
  endfunction

  // capture at posedge, update model from requirements, release strobes
  task automatic tick();
    logic [12:0] s, c;
    @(posedge clk);
    s = evt_set; c = '0;
    s[4] = s[4] | clk_stop;
    c[4] = clk_start; c[5] = rx_rd; c[6] = tx_wr;
    m_req = s | (m_req & ~c);
    if (reg_we && !reg_addr) m_mask = reg_wdata[12:0];
    m_dma = dma_en;
    #1;
    evt_set = '0; clk_start = 0; clk_stop = 0; rx_rd = 0; tx_wr = 0;
    reg_we = 0;
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    chk(irq == exp_irq(), tag, {31'b0, irq}, {31'b0, exp_irq()});
    chk(dma_rx == (m_dma & m_req[5]), {tag, " R6 rx"}, {31'b0, dma_rx}, {31'b0, m_dma & m_req[5]});
    chk(dma_tx == (m_dma & m_req[6]), {tag, " R6 tx"}, {31'b0, dma_tx}, {31'b0, m_dma & m_req[6]});
    rd(1'b1, v);
    chk(v == {19'b0, m_req}, {tag, " pending"}, v, {19'b0, m_req});
    rd(1'b0, v);
    chk(v == {19'b0, m_mask}, {tag, " R3 mask"}, v, {19'b0, m_mask});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; dma_en = 0;
    m_req = '0; m_mask = '0; m_dma = 0;
    @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic ev(logic [12:0] v);
    @(negedge clk); evt_set = v; tick();
  endtask

  task automatic wr(logic a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d; tick();
  endtask

  task automatic ctl(logic st, logic sp, logic r, logic t);
    @(negedge clk); clk_start = st; clk_stop = sp; rx_rd = r; tx_wr = t; tick();
  endtask

  task automatic set_dma(logic b);
    @(negedge clk); dma_en = b; tick();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    // R1: during reset
    chk(irq == 0 && dma_rx == 0 && dma_tx == 0, "R1 outputs in reset", {29'b0, irq, dma_rx, dma_tx}, 0);
    do_reset();
    #1;
    check_all("R1 after reset");

    // R3: width limit and read-only pending address
    wr(1'b0, 32'hFFFF_FFFF);
    check_all("R3 mask truncation");
    wr(1'b1, 32'hFFFF_FFFF);
    check_all("R3 pending write ignored");

    // R2 / R4: single-source sweep
    for (int i = 0; i < 13; i++) begin
      do_reset();
      ev(13'(1) << i);
      check_all("R2 R4 single source");
      wr(1'b0, 32'(13'(1) << i));
      check_all("R4 own bit masked");
      wr(1'b0, 32'(~(13'(1) << i)));
      check_all("R4 other bits masked");
    end

    // R5 / R6: exhaustive over bits 4..6 of pending and mask, DMA on/off
    for (int d = 0; d < 2; d++)
      for (int rp = 0; rp < 8; rp++)
        for (int mp = 0; mp < 8; mp++) begin
          do_reset();
          set_dma(d[0]);
          wr(1'b0, 32'(mp) << 4);
          ev(13'(rp) << 4);
          check_all("R5 R6 sweep");
        end

    // R7: clock stop/start
    do_reset();
    ctl(0, 1, 0, 0); check_all("R7 stop sets");
    ctl(1, 0, 0, 0); check_all("R7 start clears");
    ctl(1, 1, 0, 0); check_all("R7 both sets");

    // R8: port access clears, set wins
    do_reset();
    ev(13'h1FFF);
    ctl(0, 0, 1, 0); check_all("R8 rx read clears bit5");
    ctl(0, 0, 0, 1); check_all("R8 tx write clears bit6");
    @(negedge clk); evt_set = 13'h060; rx_rd = 1; tx_wr = 1; tick();
    check_all("R8 set wins over clear");

    // R9: change visible at the capturing edge, not before
    do_reset();
    @(negedge clk); evt_set = 13'h001; #4;
    chk(irq == 0, "R9 before edge", {31'b0, irq}, 0);
    tick();
    chk(irq == 1, "R9 at edge", {31'b0, irq}, 1);
    do_reset();
    ev(13'h020);
    check_all("R9 dma off");
    set_dma(1);
    check_all("R9 R5 dma toggle on");
    set_dma(0);
    check_all("R9 R6 dma toggle off");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule